// File: doc/BRIEF.md
# Circular Free Buffer Pool Allocator

This block gives out free buffer addresses from rings of descriptor entries kept in a small internal memory. Every entry carries a buffer address, an availability flag and an end-of-ring flag. A requester names a pool and asks for a buffer. The allocator then reads the entry that pool's current index points at. If the entry is available, the allocator returns its address and marks the entry taken. It then moves the index on by one, or back to the pool's base if the entry ends the ring. If the entry is not available, the pool is empty. In that case the allocator returns nothing, raises a sticky busy flag and sends a one-cycle interrupt carrying the pool's channel code.

Software hands buffers back by rewriting entries through a separate write port with the availability flag set. A configuration port sets a pool's base index and channel code. Writing a pool's base also moves that pool's current index to the base. The end-of-ring flag sets the length of each ring, so no length register is needed. Several pools share the memory, and each pool keeps its own base, index and code.

Top module: `fbpool_alloc`

## Requirements
- R1: After reset, reqReady is 1, gntValid, irqPulse and busyFlag are 0, and every entry's availability flag is 0. Each pool's current index equals its base, and pool p's base is p*(ENTRIES/NUM_POOLS) with channel code p. Reset applied later puts an advanced index back to its base.
- R2: A request is accepted on a rising edge where reqValid and reqReady are both 1. reqReady is 0 in the following cycle, and the outcome appears on the next rising edge after that. On a grant, gntValid is 1 for exactly one cycle and carries the entry's address and the pool number.
- R3: A granted entry's availability flag is cleared. Reaching that entry again without a software rewrite reports exhaustion.
- R4: After a grant from an entry whose end-of-ring flag is 0, the next request to that pool reads the next higher entry index.
- R5: After a grant from an entry whose end-of-ring flag is 1, the next request to that pool reads the pool's base entry.
- R6: A request that finds the availability flag at 0 gives no grant. It gives a one-cycle irqPulse with irqCode equal to the pool's channel code and leaves the index unchanged, so the same entry is tried again on the next request.
- R7: busyFlag is set by every exhaustion, stays set until busyClr is 1 at an edge, and is cleared by that. When a set and a clear land on the same edge, the flag stays set.
- R8: When software writes an entry in the same cycle that a grant clears that entry's availability flag, the software write takes effect.
- R9: A request to one pool does not change any other pool's index.
- R10: A configuration write sets the pool's base index and channel code, and it also moves the pool's current index to the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Buffer request |
| reqPool | input | POOL_W | Pool to allocate from |
| reqReady | output | 1 | Request can be accepted |
| gntValid | output | 1 | Grant strobe, one cycle |
| gntPool | output | POOL_W | Pool of the grant |
| gntPtr | output | PTR_W | Granted buffer address |
| irqPulse | output | 1 | Exhaustion interrupt, one cycle |
| irqCode | output | CODE_W | Channel code of the empty pool |
| busyFlag | output | 1 | Sticky exhaustion event |
| busyClr | input | 1 | Write-one-to-clear for busyFlag |
| swWe | input | 1 | Software entry write |
| swIdx | input | IDX_W | Entry index written |
| swPtr | input | PTR_W | Buffer address written |
| swValid | input | 1 | Availability flag written |
| swWrap | input | 1 | End-of-ring flag written |
| cfgWe | input | 1 | Pool configuration write |
| cfgPool | input | POOL_W | Pool configured |
| cfgBase | input | IDX_W | New base index |
| cfgCode | input | CODE_W | New channel code |

## Verification
A pool index that does not wrap or advance correctly shows up on that pool's next grant as a wrong address, or as a false exhaustion when the index lands on a cleared entry. That happens two edges after the request is accepted. A flag that is cleared when it should not be, or left set when it should be cleared, only shows once the ring wraps back to that entry. The bench therefore walks short rings all the way around and checks the second visit. A wrong channel code or a lost busy event shows at the exhaustion edge, on irqCode and busyFlag.

// File: rtl/fbpool_pkg.sv
package fbpool_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOOK = 1'b1
  } fbState_t;

  // Strobes from control to datapath for the entry being examined.
  typedef struct packed {
    logic consume;
    logic fail;
  } fbStrobe_t;

endpackage

// File: rtl/fbpool_ctrl.sv
module fbpool_ctrl
  import fbpool_pkg::*;
#(
  parameter int POOL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [POOL_W-1:0] reqPool,
  input  logic              entryValid,
  output logic              reqReady,
  output logic [POOL_W-1:0] selPool,
  output fbStrobe_t         strobe
);

  fbState_t state;
  logic     accept;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobe.consume = (state == ST_LOOK) && entryValid;
    strobe.fail    = (state == ST_LOOK) && !entryValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      selPool <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_LOOK;
          selPool <= reqPool;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: only one fetch in flight; an accepted request blocks the next cycle
  p_single_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R2: the examination cycle always resolves to exactly one outcome
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> $countones({strobe.consume, strobe.fail}) == 1);

endmodule

// File: rtl/fbpool_dp.sv
module fbpool_dp
  import fbpool_pkg::*;
#(
  parameter int NUM_POOLS = 4,
  parameter int ENTRIES   = 32,
  parameter int PTR_W     = 32,
  parameter int CODE_W    = 8,
  parameter int POOL_W    = 2,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [POOL_W-1:0] selPool,
  input  fbStrobe_t         strobe,
  output logic              entryValid,
  output logic              gntValid,
  output logic [POOL_W-1:0] gntPool,
  output logic [PTR_W-1:0]  gntPtr,
  output logic              irqPulse,
  output logic [CODE_W-1:0] irqCode,
  output logic              busyFlag,
  input  logic              busyClr,
  input  logic              swWe,
  input  logic [IDX_W-1:0]  swIdx,
  input  logic [PTR_W-1:0]  swPtr,
  input  logic              swValid,
  input  logic              swWrap,
  input  logic              cfgWe,
  input  logic [POOL_W-1:0] cfgPool,
  input  logic [IDX_W-1:0]  cfgBase,
  input  logic [CODE_W-1:0] cfgCode
);

  localparam int STRIDE = ENTRIES / NUM_POOLS;

  // Entry memory
  logic [PTR_W-1:0]  entPtr  [ENTRIES];
  logic              entWrap [ENTRIES];
  logic              entV    [ENTRIES];

  // Per-pool registers
  logic [IDX_W-1:0]  poolBase [NUM_POOLS];
  logic [IDX_W-1:0]  poolCur  [NUM_POOLS];
  logic [CODE_W-1:0] poolCode [NUM_POOLS];

  logic [IDX_W-1:0]  lookIdx;
  logic              entryWrap;
  logic [PTR_W-1:0]  entryPtr;
  logic              cfgHitSel;

  assign lookIdx    = poolCur[selPool];
  assign entryValid = entV[lookIdx];
  assign entryWrap  = entWrap[lookIdx];
  assign entryPtr   = entPtr[lookIdx];
  assign cfgHitSel  = cfgWe && (cfgPool == selPool);

  // Address and wrap fields: written by software only
  always_ff @(posedge clk) begin
    if (swWe) begin
      entPtr[swIdx]  <= swPtr;
      entWrap[swIdx] <= swWrap;
    end
  end

  // Availability flags: software write wins over a hardware clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) entV[i] <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (swWe && swIdx == IDX_W'(i))
          entV[i] <= swValid;
        else if (strobe.consume && lookIdx == IDX_W'(i))
          entV[i] <= 1'b0;
      end
    end
  end

  // Pool base, index and code registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_POOLS; p++) begin
        poolBase[p] <= IDX_W'(p * STRIDE);
        poolCur[p]  <= IDX_W'(p * STRIDE);
        poolCode[p] <= CODE_W'(p);
      end
    end else begin
      for (int p = 0; p < NUM_POOLS; p++) begin
        if (cfgWe && cfgPool == POOL_W'(p)) begin
          poolBase[p] <= cfgBase;
          poolCur[p]  <= cfgBase;
          poolCode[p] <= cfgCode;
        end else if (strobe.consume && selPool == POOL_W'(p)) begin
          poolCur[p] <= entryWrap ? poolBase[p] : poolCur[p] + 1'b1;
        end
      end
    end
  end

  // Outcome registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gntValid <= 1'b0;
      gntPool  <= '0;
      gntPtr   <= '0;
      irqPulse <= 1'b0;
      irqCode  <= '0;
      busyFlag <= 1'b0;
    end else begin
      gntValid <= strobe.consume;
      irqPulse <= strobe.fail;
      if (strobe.consume) begin
        gntPtr  <= entryPtr;
        gntPool <= selPool;
      end
      if (strobe.fail) irqCode <= poolCode[selPool];
      busyFlag <= strobe.fail | (busyFlag & ~busyClr);
    end
  end

  // R6: a grant and an exhaustion never report together
  p_excl_outcome_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(gntValid && irqPulse));

  // R6: exhaustion leaves the pool's index where it was
  p_fail_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fail && !cfgHitSel) |=> $stable(poolCur[selPool]));

  // R4: a grant from a non-final entry moves the index up by one
  p_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.consume && !entryWrap && !cfgHitSel) |=>
      poolCur[selPool] == IDX_W'($past(lookIdx) + 1'b1));

  // R5: a grant from the final entry returns the index to the base
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.consume && entryWrap && !cfgHitSel) |=>
      poolCur[selPool] == poolBase[selPool]);

  // R7: every interrupt is accompanied by the sticky flag
  p_irq_sets_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> busyFlag);

  // R7: the flag only drops through the clear input
  p_busy_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busyFlag && !busyClr) |=> busyFlag);

endmodule

// File: rtl/fbpool_alloc.sv
module fbpool_alloc
  import fbpool_pkg::*;
#(
  parameter int NUM_POOLS = 4,
  parameter int ENTRIES   = 32,
  parameter int PTR_W     = 32,
  parameter int CODE_W    = 8,
  localparam int POOL_W   = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [POOL_W-1:0] reqPool,
  output logic              reqReady,
  output logic              gntValid,
  output logic [POOL_W-1:0] gntPool,
  output logic [PTR_W-1:0]  gntPtr,
  output logic              irqPulse,
  output logic [CODE_W-1:0] irqCode,
  output logic              busyFlag,
  input  logic              busyClr,
  input  logic              swWe,
  input  logic [IDX_W-1:0]  swIdx,
  input  logic [PTR_W-1:0]  swPtr,
  input  logic              swValid,
  input  logic              swWrap,
  input  logic              cfgWe,
  input  logic [POOL_W-1:0] cfgPool,
  input  logic [IDX_W-1:0]  cfgBase,
  input  logic [CODE_W-1:0] cfgCode
);

  logic [POOL_W-1:0] selPool;
  fbStrobe_t         strobe;
  logic              entryValid;

  fbpool_ctrl #(.POOL_W(POOL_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqPool    (reqPool),
    .entryValid (entryValid),
    .reqReady   (reqReady),
    .selPool    (selPool),
    .strobe     (strobe)
  );

  fbpool_dp #(
    .NUM_POOLS (NUM_POOLS),
    .ENTRIES   (ENTRIES),
    .PTR_W     (PTR_W),
    .CODE_W    (CODE_W),
    .POOL_W    (POOL_W),
    .IDX_W     (IDX_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .selPool    (selPool),
    .strobe     (strobe),
    .entryValid (entryValid),
    .gntValid   (gntValid),
    .gntPool    (gntPool),
    .gntPtr     (gntPtr),
    .irqPulse   (irqPulse),
    .irqCode    (irqCode),
    .busyFlag   (busyFlag),
    .busyClr    (busyClr),
    .swWe       (swWe),
    .swIdx      (swIdx),
    .swPtr      (swPtr),
    .swValid    (swValid),
    .swWrap     (swWrap),
    .cfgWe      (cfgWe),
    .cfgPool    (cfgPool),
    .cfgBase    (cfgBase),
    .cfgCode    (cfgCode)
  );

  // R1: nothing is reported straight out of reset
  p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!gntValid && !irqPulse));

endmodule

// File: tb/fbpool_alloc_test.sv
`timescale 1ns/1ps
module fbpool_alloc_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqPool;
  logic        reqReady;
  logic        gntValid;
  logic [1:0]  gntPool;
  logic [31:0] gntPtr;
  logic        irqPulse;
  logic [7:0]  irqCode;
  logic        busyFlag;
  logic        busyClr;
  logic        swWe;
  logic [4:0]  swIdx;
  logic [31:0] swPtr;
  logic        swValid;
  logic        swWrap;
  logic        cfgWe;
  logic [1:0]  cfgPool;
  logic [4:0]  cfgBase;
  logic [7:0]  cfgCode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fbpool_alloc uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPool(reqPool),
    .reqReady(reqReady), .gntValid(gntValid), .gntPool(gntPool),
    .gntPtr(gntPtr), .irqPulse(irqPulse), .irqCode(irqCode),
    .busyFlag(busyFlag), .busyClr(busyClr), .swWe(swWe), .swIdx(swIdx),
    .swPtr(swPtr), .swValid(swValid), .swWrap(swWrap), .cfgWe(cfgWe),
    .cfgPool(cfgPool), .cfgBase(cfgBase), .cfgCode(cfgCode)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [4:0] idx, input logic [31:0] ptr,
                            input logic v, input logic w);
    @(negedge clk);
    swWe = 1'b1; swIdx = idx; swPtr = ptr; swValid = v; swWrap = w;
    @(negedge clk);
    swWe = 1'b0;
  endtask

  // One request; optional software write and busy clear during the look cycle.
  task automatic fetch(input logic [1:0] pool, input logic expGnt,
                       input logic [31:0] expPtr, input logic [7:0] expCode,
                       input string req, input bit doWr, input logic [4:0] wIdx,
                       input logic [31:0] wPtr, input bit doClr);
    @(negedge clk);
    reqValid = 1'b1; reqPool = pool;
    @(posedge clk); #1;
    check(reqReady == 1'b0, "R2", "ready low after accept", 32'(reqReady), 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    if (doWr) begin
      swWe = 1'b1; swIdx = wIdx; swPtr = wPtr; swValid = 1'b1; swWrap = 1'b1;
    end
    busyClr = doClr;
    @(posedge clk); #1;
    swWe = 1'b0; busyClr = 1'b0;
    check(gntValid == expGnt, req, "gntValid", 32'(gntValid), 32'(expGnt));
    check(irqPulse == !expGnt, req, "irqPulse", 32'(irqPulse), 32'(!expGnt));
    if (expGnt) begin
      check(gntPtr == expPtr, req, "gntPtr", gntPtr, expPtr);
      check(gntPool == pool, req, "gntPool", 32'(gntPool), 32'(pool));
    end else begin
      check(irqCode == expCode, req, "irqCode", 32'(irqCode), 32'(expCode));
    end
    @(posedge clk); #1;
    check(!gntValid && !irqPulse, "R2", "single-cycle outcome",
          32'({gntValid, irqPulse}), 32'd0);
  endtask

  typedef struct packed {
    logic [1:0]  pool;
    logic        expGnt;
    logic [31:0] expPtr;
    logic [7:0]  expCode;
  } vec_t;

  // Setup: pool0 ring 0..2 (A0,A1,A2 final), pool1 ring of one at 8 (B0)
  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b1, 32'hA000_0000, 8'd0},  // R4 first entry of pool 0
    '{2'd1, 1'b1, 32'hB000_0000, 8'd0},  // R9 pool 1 unaffected by pool 0
    '{2'd0, 1'b1, 32'hA000_0001, 8'd0},  // R4 next index
    '{2'd1, 1'b0, 32'h0,         8'd1},  // R3 pool 1 wrapped onto its cleared entry
    '{2'd0, 1'b1, 32'hA000_0002, 8'd0},  // R5 final entry of ring
    '{2'd0, 1'b0, 32'h0,         8'd0}   // R3/R5 back at base, flag cleared
  };

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqPool = '0; busyClr = 1'b0;
    swWe = 1'b0; swIdx = '0; swPtr = '0; swValid = 1'b0; swWrap = 1'b0;
    cfgWe = 1'b0; cfgPool = '0; cfgBase = '0; cfgCode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady", 32'(reqReady), 32'd1);
    check(!gntValid && !irqPulse, "R1", "no outcome", 32'({gntValid, irqPulse}), 32'd0);
    check(busyFlag == 1'b0, "R1", "busyFlag", 32'(busyFlag), 32'd0);

    writeEntry(5'd0, 32'hA000_0000, 1'b1, 1'b0);
    writeEntry(5'd1, 32'hA000_0001, 1'b1, 1'b0);
    writeEntry(5'd2, 32'hA000_0002, 1'b1, 1'b1);
    writeEntry(5'd8, 32'hB000_0000, 1'b1, 1'b1);

    for (int i = 0; i < 6; i++)
      fetch(VECS[i].pool, VECS[i].expGnt, VECS[i].expPtr, VECS[i].expCode,
            "R4/R5/R3/R9 vector", 1'b0, '0, '0, 1'b0);

    // R7 sticky and write-one-to-clear
    check(busyFlag == 1'b1, "R7", "busy set after exhaustion", 32'(busyFlag), 32'd1);
    repeat (2) @(negedge clk);
    check(busyFlag == 1'b1, "R7", "busy holds", 32'(busyFlag), 32'd1);
    busyClr = 1'b1;
    @(posedge clk); #1;
    busyClr = 1'b0;
    check(busyFlag == 1'b0, "R7", "busy cleared", 32'(busyFlag), 32'd0);

    // R6 retry same entry after software returns a buffer
    fetch(2'd0, 1'b0, 32'h0, 8'd0, "R6", 1'b0, '0, '0, 1'b0);
    writeEntry(5'd0, 32'hA000_0009, 1'b1, 1'b1);
    fetch(2'd0, 1'b1, 32'hA000_0009, 8'd0, "R6", 1'b0, '0, '0, 1'b0);

    // R7 set wins over a simultaneous clear
    busyClr = 1'b1;
    @(posedge clk); #1;
    busyClr = 1'b0;
    fetch(2'd0, 1'b0, 32'h0, 8'd0, "R7", 1'b0, '0, '0, 1'b1);
    check(busyFlag == 1'b1, "R7", "set wins over clear", 32'(busyFlag), 32'd1);

    // R8 software write collides with hardware clear
    writeEntry(5'd16, 32'hC000_0000, 1'b1, 1'b1);
    fetch(2'd2, 1'b1, 32'hC000_0000, 8'd0, "R8", 1'b1, 5'd16, 32'hC000_0001, 1'b0);
    fetch(2'd2, 1'b1, 32'hC000_0001, 8'd0, "R8", 1'b0, '0, '0, 1'b0);
    fetch(2'd2, 1'b0, 32'h0, 8'd2, "R8", 1'b0, '0, '0, 1'b0);

    // R10 configuration write
    @(negedge clk);
    cfgWe = 1'b1; cfgPool = 2'd3; cfgBase = 5'd20; cfgCode = 8'h5A;
    @(negedge clk);
    cfgWe = 1'b0;
    writeEntry(5'd20, 32'hD000_0000, 1'b1, 1'b1);
    fetch(2'd3, 1'b1, 32'hD000_0000, 8'd0, "R10", 1'b0, '0, '0, 1'b0);
    fetch(2'd3, 1'b0, 32'h0, 8'h5A, "R10", 1'b0, '0, '0, 1'b0);

    // R1 reset restores index to base and default codes
    writeEntry(5'd0, 32'hE000_0000, 1'b1, 1'b0);
    fetch(2'd0, 1'b1, 32'hE000_0000, 8'd0, "R1", 1'b0, '0, '0, 1'b0);
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    #1;
    check(busyFlag == 1'b0, "R1", "busy after reset", 32'(busyFlag), 32'd0);
    check(reqReady == 1'b1, "R1", "ready after reset", 32'(reqReady), 32'd1);
    writeEntry(5'd0, 32'hF000_0000, 1'b1, 1'b0);
    fetch(2'd0, 1'b1, 32'hF000_0000, 8'd0, "R1", 1'b0, '0, '0, 1'b0);
    fetch(2'd3, 1'b0, 32'h0, 8'd3, "R1", 1'b0, '0, '0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule